// File: doc/BRIEF.md
# External Interrupt Sense and Status Register

This block is one 16-bit control and status word of an interrupt controller together with the input logic for two external interrupt pins, both active low. Each pin passes through a synchronizer and is then sensed either as a low level or as a falling edge, as software selects. A falling edge sets a request flag. That flag holds until the core accepts the interrupt for that pin. A level request follows the synchronized pin. While the chip is in a low-power mode, both pins are sensed by level whatever their mode bits hold. One global disable bit masks every request the block drives.

When the core accepts an interrupt, it pulses a strobe along with the priority level and vector number it is presenting, and the block captures both values into read-only fields. These fields change only on such a strobe, so a nested acceptance replaces the values of the one before it. The priority field says which nesting levels may still interrupt. Code 0 allows levels 0 to 3, code 1 allows levels 1 to 3, code 2 allows levels 2 and 3, and code 3 allows level 3 only. The read port shows the register at all times, with the live synchronized pin levels and a flag that is set while any request goes to the core.

Top module: `irq_csr`

## Requirements
- R1: After reset, with both pins idle high, the word reads 0x001C. Capture fields, disable and both mode bits are 0.
- R2: Bit 4 always reads 1. Writing to it has no effect.
- R3: A write loads bit 5 (disable), bit 1 (mode of pin 1) and bit 0 (mode of pin 0), with 1 meaning falling edge and 0 meaning low level. The written values of bits 15 to 6 and bits 4 to 2 have no effect.
- R4: On a cycle with take_i high, bits 14:13 capture take_prio_i and bits 12:6 capture take_vec_i. The new values are visible after that clock edge.
- R5: Bits 14:6 keep their value on every cycle with take_i low, whether or not a write occurs.
- R6: A second take_i replaces the values captured by the first one.
- R7: Bit 2 shows the level of pin 0 and bit 3 shows the level of pin 1, after a two-flop synchronizer.
- R8: In level mode, req_o[k] is 1 while synchronized pin k is low and 0 once it is high again.
- R9: In edge mode, a falling edge on pin k sets req_o[k]. It stays set after the pin returns high and clears on take_i together with take_pin_i[k] high.
- R10: While lowpwr_i is high, a pin in edge mode behaves as in level mode. It asserts while low, deasserts when high, and latches nothing.
- R11: While bit 5 is 1, req_o is 0. Clearing bit 5 restores any request that is pending.
- R12: Bit 15 reads 1 exactly when some bit of req_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Current register contents |
| pin_n_i | input | 2 | Raw external interrupt pins, active low |
| lowpwr_i | input | 1 | Chip is in a stop or wait mode |
| take_i | input | 1 | Core accepted an interrupt this cycle |
| take_prio_i | input | 2 | Priority level presented at acceptance |
| take_vec_i | input | 7 | Vector address bits [7:1] at acceptance |
| take_pin_i | input | 2 | One-hot: accepted source is external pin k |
| req_o | output | 2 | Request to the core from each external pin |

## Verification
The assertions assume take_i is a single-cycle strobe and take_pin_i is at most one-hot. They also assume that a write and an acceptance do not both touch the same captured bits, and since writes never reach those bits this is always true. The stimulus holds pins steady for several cycles around each change. Every value the bench compares is therefore counted from the fixed two-flop synchronizer delay and not from racing edges. The bench drives take_pin_i only with 00, 01 or 10, and it moves lowpwr_i only while the pins are idle.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;
    localparam int REG_W     = 16;
    localparam int PRIO_W    = 2;
    localparam int VEC_W     = 7;
    localparam int NPIN      = 2;
    localparam int PEND_BIT  = 15;
    localparam int PRIO_LSB  = 13;
    localparam int VEC_LSB   = 6;
    localparam int DIS_BIT   = 5;
    localparam int RSVD_BIT  = 4;
    localparam int STATE_LSB = 2;
    localparam int MODE_LSB  = 0;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic [VEC_W-1:0]  vec;
    } cap_t;

    typedef struct packed {
        logic            dis;
        logic [NPIN-1:0] edge_mode;
    } ctrl_t;
endpackage

// File: rtl/irq_pin_sense.sv
module irq_pin_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_i,
    input  logic edge_en_i,
    input  logic ack_i,
    output logic level_o,
    output logic req_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   latch;
    } st_t;

    st_t st_d, st_q;
    logic fall;

    assign level_o = st_q.sync[SYNC_STAGES-1];
    assign fall    = st_q.prev & ~level_o;
    assign req_o   = edge_en_i ? st_q.latch : ~level_o;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin_n_i};
        st_d.prev = level_o;
        if (!edge_en_i)  st_d.latch = 1'b0;
        else if (fall)   st_d.latch = 1'b1;   // new edge wins over ack
        else if (ack_i)  st_d.latch = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync  <= '1;
            st_q.prev  <= 1'b1;
            st_q.latch <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/irq_csr_regs.sv
module irq_csr_regs
    import irq_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              wr_dis_i,
    input  logic [NPIN-1:0]   wr_mode_i,
    input  logic              take_i,
    input  logic [PRIO_W-1:0] prio_i,
    input  logic [VEC_W-1:0]  vec_i,
    output ctrl_t             ctrl_o,
    output cap_t              cap_o
);
    typedef struct packed {
        ctrl_t ctrl;
        cap_t  cap;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_i) begin
            r_d.ctrl.dis       = wr_dis_i;
            r_d.ctrl.edge_mode = wr_mode_i;
        end
        if (take_i) begin
            r_d.cap.prio = prio_i;
            r_d.cap.vec  = vec_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctrl_o = r_q.ctrl;
    assign cap_o  = r_q.cap;
endmodule

// File: rtl/irq_csr.sv
module irq_csr
    import irq_csr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [NPIN-1:0]   pin_n_i,
    input  logic              lowpwr_i,
    input  logic              take_i,
    input  logic [PRIO_W-1:0] take_prio_i,
    input  logic [VEC_W-1:0]  take_vec_i,
    input  logic [NPIN-1:0]   take_pin_i,
    output logic [NPIN-1:0]   req_o
);
    ctrl_t           ctrl;
    cap_t            cap;
    logic [NPIN-1:0] level;
    logic [NPIN-1:0] raw_req;

    irq_csr_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reg_wr),
        .wr_dis_i  (reg_wdata[DIS_BIT]),
        .wr_mode_i (reg_wdata[MODE_LSB +: NPIN]),
        .take_i    (take_i),
        .prio_i    (take_prio_i),
        .vec_i     (take_vec_i),
        .ctrl_o    (ctrl),
        .cap_o     (cap)
    );

    for (genvar k = 0; k < NPIN; k++) begin : g_pin
        irq_pin_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n_i   (pin_n_i[k]),
            .edge_en_i (ctrl.edge_mode[k] & ~lowpwr_i),
            .ack_i     (take_i & take_pin_i[k]),
            .level_o   (level[k]),
            .req_o     (raw_req[k])
        );
    end

    assign req_o = raw_req & {NPIN{~ctrl.dis}};

    always_comb begin
        reg_rdata                        = '0;
        reg_rdata[PEND_BIT]              = |req_o;
        reg_rdata[PRIO_LSB +: PRIO_W]    = cap.prio;
        reg_rdata[VEC_LSB +: VEC_W]      = cap.vec;
        reg_rdata[DIS_BIT]               = ctrl.dis;
        reg_rdata[RSVD_BIT]              = 1'b1;
        reg_rdata[STATE_LSB +: NPIN]     = level;
        reg_rdata[MODE_LSB +: NPIN]      = ctrl.edge_mode;
    end
endmodule

// File: rtl/irq_csr_chk.sv
module irq_csr_chk
    import irq_csr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              take_i,
    input logic [PRIO_W-1:0] take_prio_i,
    input logic [VEC_W-1:0]  take_vec_i,
    input logic [NPIN-1:0]   req_o
);
    assert_rsvd_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[RSVD_BIT]);

    assert_ctrl_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_rdata[DIS_BIT] == $past(reg_wdata[DIS_BIT])) &&
                   (reg_rdata[MODE_LSB +: NPIN] == $past(reg_wdata[MODE_LSB +: NPIN])));

    assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> (reg_rdata[PRIO_LSB +: PRIO_W] == $past(take_prio_i)) &&
                   (reg_rdata[VEC_LSB +: VEC_W] == $past(take_vec_i)));

    assert_capture_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> $stable(reg_rdata[PEND_BIT-1:VEC_LSB]));

    assert_disable_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DIS_BIT] |-> (req_o == '0));

    assert_pend_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[PEND_BIT] == (req_o != '0));
endmodule

bind irq_csr irq_csr_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .take_i      (take_i),
    .take_prio_i (take_prio_i),
    .take_vec_i  (take_vec_i),
    .req_o       (req_o)
);

// File: tb/irq_csr_bench.sv
module irq_csr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [1:0]  pin_n_i = 2'b11;
    logic        lowpwr_i = 1'b0;
    logic        take_i = 1'b0;
    logic [1:0]  take_prio_i = '0;
    logic [6:0]  take_vec_i = '0;
    logic [1:0]  take_pin_i = '0;
    logic [1:0]  req_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    irq_csr u_irq_csr (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pin_n_i(pin_n_i), .lowpwr_i(lowpwr_i),
        .take_i(take_i), .take_prio_i(take_prio_i), .take_vec_i(take_vec_i),
        .take_pin_i(take_pin_i), .req_o(req_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        step(1);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic take(input logic [1:0] p, input logic [6:0] v, input logic [1:0] src);
        take_i = 1'b1; take_prio_i = p; take_vec_i = v; take_pin_i = src;
        step(1);
        take_i = 1'b0; take_prio_i = '0; take_vec_i = '0; take_pin_i = '0;
    endtask

    function automatic logic [15:0] cap_word(input logic [1:0] p, input logic [6:0] v);
        return {1'b0, p, v, 6'b0};
    endfunction

    task automatic t_reset;
        chk("R1 reset word", reg_rdata, 16'h001C);
        chk("R1 reset req", {14'b0, req_o}, 16'h0000);
    endtask

    task automatic t_write;
        wr(16'hFFFF);
        chk("R3 write all ones", reg_rdata, 16'h003F);
        chk("R2 reserved after ones", {15'b0, reg_rdata[4]}, 16'h0001);
        wr(16'h0000);
        chk("R2 reserved after zeros", reg_rdata, 16'h001C);
    endtask

    task automatic t_capture;
        take(2'b10, 7'h55, 2'b00);
        chk("R4 capture", reg_rdata, cap_word(2'b10, 7'h55) | 16'h001C);
        wr(16'hFFC0);
        chk("R5 write keeps capture", reg_rdata, cap_word(2'b10, 7'h55) | 16'h001C);
        step(3);
        chk("R5 idle keeps capture", reg_rdata, cap_word(2'b10, 7'h55) | 16'h001C);
        take(2'b01, 7'h2A, 2'b00);
        chk("R6 nested overwrite", reg_rdata, cap_word(2'b01, 7'h2A) | 16'h001C);
        take(2'b11, 7'h7F, 2'b00);
        chk("R6 second overwrite", reg_rdata, cap_word(2'b11, 7'h7F) | 16'h001C);
        take(2'b00, 7'h00, 2'b00);
    endtask

    task automatic t_level;
        pin_n_i[1] = 1'b0;
        step(1);
        chk("R7 not yet synced", {14'b0, req_o}, 16'h0000);
        step(1);
        chk("R8 level req pin1", {14'b0, req_o}, 16'h0002);
        chk("R7 state bit3 low", reg_rdata, 16'h8014);
        pin_n_i[1] = 1'b1;
        step(3);
        chk("R8 level release", {14'b0, req_o}, 16'h0000);
        pin_n_i[0] = 1'b0;
        step(3);
        chk("R7 state bit2 low", reg_rdata, 16'h8018);
        pin_n_i[0] = 1'b1;
        step(3);
    endtask

    task automatic t_edge;
        wr(16'h0001);
        pin_n_i[0] = 1'b0;
        step(4);
        chk("R9 edge sets", {14'b0, req_o}, 16'h0001);
        pin_n_i[0] = 1'b1;
        step(4);
        chk("R9 edge held after release", {14'b0, req_o}, 16'h0001);
        chk("R12 pending flag", {15'b0, reg_rdata[15]}, 16'h0001);
        take(2'b00, 7'h00, 2'b10);
        chk("R9 other-pin ack ignored", {14'b0, req_o}, 16'h0001);
        take(2'b00, 7'h00, 2'b01);
        chk("R9 ack clears", {14'b0, req_o}, 16'h0000);
        chk("R12 flag clears", {15'b0, reg_rdata[15]}, 16'h0000);
        wr(16'h0000);
    endtask

    task automatic t_lowpwr;
        wr(16'h0002);
        lowpwr_i = 1'b1;
        pin_n_i[1] = 1'b0;
        step(3);
        chk("R10 lowpwr level assert", {14'b0, req_o}, 16'h0002);
        pin_n_i[1] = 1'b1;
        step(3);
        chk("R10 lowpwr no latch", {14'b0, req_o}, 16'h0000);
        lowpwr_i = 1'b0;
        step(2);
        chk("R10 no edge after exit", {14'b0, req_o}, 16'h0000);
        wr(16'h0000);
    endtask

    task automatic t_disable;
        wr(16'h0020);
        pin_n_i[0] = 1'b0;
        step(3);
        chk("R11 masked req", {14'b0, req_o}, 16'h0000);
        chk("R11 masked word", reg_rdata, 16'h0038);
        wr(16'h0000);
        chk("R11 unmasked req", {14'b0, req_o}, 16'h0001);
        pin_n_i[0] = 1'b1;
        step(3);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        step(2);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_write();
        t_capture();
        t_level();
        t_edge();
        t_lowpwr();
        t_disable();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule